// File: doc/BRIEF.md
# Edge-Latched Interrupt Aggregator

This block collects a set of peripheral interrupt lines and turns them into a single request towards a processor. Every line goes through its own edge detector. A low-to-high transition on a line latches a pending flag in a status register. Software reads that register to learn which sources fired. It acknowledges a source by writing a word in which that source's bit is zero. An enable mask chooses which pending flags may raise the processor request.

The two registers sit on a small memory-mapped port. A transfer is a one-cycle strobe that carries a write flag, a byte offset and write data. Read data comes back registered on the following cycle. Offsets that map to neither register read as all ones, and writes to them are dropped. The processor request is registered. It follows the AND of status and mask with one cycle of delay.

The default build has eleven lines. Bit 0 is vertical blank, then graphics, optical drive, DMA, timers 0 to 2, controller pad, serial I/O and sound, and bit 10 is a spare line.

Top module: `irq_hub`

## Requirements
- R1: When line i is low in one sampled cycle and high in the next, status bit i (bit 0 = vertical blank through bit 10 = spare) is set at the clock edge that samples the high level.
- R2: A status bit is never set without a rising edge. A line that stays high does not set the bit again after it is cleared, and a falling edge leaves the status unchanged.
- R3: A write to offset 0x00 replaces the status with the bitwise AND of the current status and the write data. A 0 clears a bit and a 1 keeps it. Status bits 31..11 always read as zero.
- R4: A write to offset 0x04 stores write data bits 10..0 in the mask. Mask bits 31..11 read as zero.
- R5: A read at offset 0x00 returns the status and a read at offset 0x04 returns the mask. Either value appears on the read data port one clock after the strobe and shows the register as it was before that edge.
- R6: A read at any other offset returns 0xFFFFFFFF one clock later. A write to any other offset changes neither register.
- R7: The request output equals the OR of (status AND mask) as it stood one clock earlier.
- R8: Reset clears the status, the mask, the stored previous line levels, the read data and the request.
- R9: When a rising edge and a status write that clears the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Peripheral request levels, synchronous to clk |
| bus_valid_i | input | 1 | One-cycle transfer strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the transfer |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read strobe |
| irq_req_o | output | 1 | Registered processor interrupt request |

## Verification
The bench uses the default parameters: eleven lines, a 32-bit data path and an 8-bit offset. This leaves 21 unused upper bits in every register, so the zero-fill of status and mask shows up on each read. The 8-bit offset gives 254 unmapped offsets, and the random traffic hits several of them. Random line activity combined with random acknowledges often puts a rising edge in the same cycle as a clear of that bit. A short offset space with many line toggles makes these collisions, and the all-ones reads, frequent events rather than rare ones.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int unsigned STATUS_OFS = 0;
  localparam int unsigned MASK_OFS   = 4;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lines_i[i];
    end
    assign rise_o[i] = lines_i[i] & ~prev_q[i];
  end

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_status_o,
  output logic              wr_mask_o,
  output logic              rd_en_o
);

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(STATUS_OFS))    return SEL_STATUS;
    else if (a == ADDR_W'(MASK_OFS)) return SEL_MASK;
    else                             return SEL_NONE;
  endfunction

  always_comb begin
    sel_o       = decode_offset(addr_i);
    wr_status_o = valid_i & write_i & (sel_o == SEL_STATUS);
    wr_mask_o   = valid_i & write_i & (sel_o == SEL_MASK);
    rd_en_o     = valid_i & ~write_i;
  end

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_hub_pkg::*;
#(
  parameter int unsigned N      = 11,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      rise_i,
  input  logic              wr_status_i,
  input  logic              wr_mask_i,
  input  logic              rd_en_i,
  input  reg_sel_e          rd_sel_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      status_o,
  output logic [N-1:0]      mask_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [N-1:0]      status_q, mask_q, status_d;
  logic [DATA_W-1:0] rdata_q, rd_word;

  // Acknowledge ANDs, then new edges OR in so a same-cycle edge survives.
  function automatic logic [N-1:0] status_update(
    input logic [N-1:0] cur, input logic ack, input logic [N-1:0] keep,
    input logic [N-1:0] rise);
    logic [N-1:0] t;
    t = ack ? (cur & keep) : cur;
    return t | rise;
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [N-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[N-1:0] = v;
    return w;
  endfunction

  always_comb begin
    status_d = status_update(status_q, wr_status_i, wdata_i, rise_i);
    unique case (rd_sel_i)
      SEL_STATUS: rd_word = widen(status_q);
      SEL_MASK:   rd_word = widen(mask_q);
      default:    rd_word = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      rdata_q  <= '0;
    end else begin
      status_q <= status_d;
      if (wr_mask_i) mask_q  <= wdata_i;
      if (rd_en_i)   rdata_q <= rd_word;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign rdata_o  = rdata_q;

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  output logic         pending_o,
  output logic         req_o
);

  function automatic logic any_enabled(input logic [N-1:0] s, input logic [N-1:0] m);
    return |(s & m);
  endfunction

  assign pending_o = any_enabled(status_i, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= pending_o;
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_LINES = 11,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_req_o
);

  // Named internal events, observed by the bound checker.
  logic [NUM_LINES-1:0] rise_vec;
  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] mask_q;
  logic                 wr_status;
  logic                 wr_mask;
  logic                 rd_en;
  logic                 pending;
  reg_sel_e             rd_sel;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NUM_LINES];

  irq_edge_detect #(.N(NUM_LINES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (irq_lines_i),
    .rise_o  (rise_vec)
  );

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i     (bus_valid_i),
    .write_i     (bus_write_i),
    .addr_i      (bus_addr_i),
    .sel_o       (rd_sel),
    .wr_status_o (wr_status),
    .wr_mask_o   (wr_mask),
    .rd_en_o     (rd_en)
  );

  irq_reg_file #(.N(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise_vec),
    .wr_status_i (wr_status),
    .wr_mask_i   (wr_mask),
    .rd_en_i     (rd_en),
    .rd_sel_i    (rd_sel),
    .wdata_i     (bus_wdata_i[NUM_LINES-1:0]),
    .status_o    (status_q),
    .mask_o      (mask_q),
    .rdata_o     (bus_rdata_o)
  );

  irq_req_gen #(.N(NUM_LINES)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (status_q),
    .mask_i    (mask_q),
    .pending_o (pending),
    .req_o     (irq_req_o)
  );

endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
  parameter int unsigned NUM_LINES = 11,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid_i,
  input logic                 bus_write_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [DATA_W-1:0]    bus_wdata_i,
  input logic [DATA_W-1:0]    bus_rdata_o,
  input logic                 irq_req_o,
  input logic [NUM_LINES-1:0] rise_vec,
  input logic [NUM_LINES-1:0] status_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic                 wr_status
);

  logic rd_status, rd_mask, rd_other, wr_other, wr_mask_c;
  logic [DATA_W-1:0] status_w, mask_w;

  always_comb begin
    rd_status = bus_valid_i & ~bus_write_i & (bus_addr_i == ADDR_W'(0));
    rd_mask   = bus_valid_i & ~bus_write_i & (bus_addr_i == ADDR_W'(4));
    rd_other  = bus_valid_i & ~bus_write_i & (bus_addr_i != ADDR_W'(0)) & (bus_addr_i != ADDR_W'(4));
    wr_other  = bus_valid_i &  bus_write_i & (bus_addr_i != ADDR_W'(0)) & (bus_addr_i != ADDR_W'(4));
    wr_mask_c = bus_valid_i &  bus_write_i & (bus_addr_i == ADDR_W'(4));
    status_w  = '0;
    status_w[NUM_LINES-1:0] = status_q;
    mask_w    = '0;
    mask_w[NUM_LINES-1:0] = mask_q;
  end

  // R1
  a_r1_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_vec) |=> ((status_q & $past(rise_vec)) == $past(rise_vec)));

  // R2
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_vec) || !(|rise_vec) |=> ((status_q & ~$past(status_q) & ~$past(rise_vec)) == '0));

  // R2: without an acknowledge nothing is cleared
  a_r2_no_clear_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> (($past(status_q) & ~status_q) == '0));

  // R9 and R3
  a_r9_ack_then_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> (status_q == ($past(status_q & bus_wdata_i[NUM_LINES-1:0]) | $past(rise_vec))));

  // R4
  a_r4_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_c |=> (mask_q == $past(bus_wdata_i[NUM_LINES-1:0])));

  // R5 and R3
  a_r5_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> (bus_rdata_o == $past(status_w)));

  a_r5_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mask |=> (bus_rdata_o == $past(mask_w)));

  // R6
  a_r6_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_other |=> (bus_rdata_o == '1));

  a_r6_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> ($stable(mask_q) && (($past(status_q) & ~status_q) == '0)));

  // R7
  a_r7_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o == $past(|(status_q & mask_q)));

endmodule

bind irq_hub irq_hub_checker #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_req_o   (irq_req_o),
  .rise_vec    (rise_vec),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .wr_status   (wr_status)
);

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;

  localparam int unsigned NL = 11;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam logic [DW-1:0] LOW_MASK = (32'd1 << NL) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic          valid = 1'b0, write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          req;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_status = '0, m_mask = '0;
  logic [NL-1:0] m_prev = '0;
  logic          m_req = 1'b0;
  logic [DW-1:0] m_rdata = '0;

  always #2 clk = ~clk;

  irq_hub #(.NUM_LINES(NL), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .bus_valid_i(valid),
    .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_req_o(req));

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a,
      input logic [DW-1:0] st, input logic [DW-1:0] mk);
    if (a == 8'h00)      return st;
    else if (a == 8'h04) return mk;
    else                 return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [DW-1:0] exp_status(input logic [DW-1:0] st,
      input bit ack, input logic [DW-1:0] d, input logic [DW-1:0] rise);
    logic [DW-1:0] kept;
    kept = ack ? (st & d) : st;
    return (kept | rise) & LOW_MASK;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic [NL-1:0] l, input bit v, input bit w,
      input logic [AW-1:0] a, input logic [DW-1:0] d, input string rtag);
    logic [DW-1:0] rise, n_status, n_mask;
    bit n_req, is_rd;
    @(negedge clk);
    lines = l; valid = v; write = w; addr = a; wdata = d;
    rise     = {{(DW-NL){1'b0}}, l & ~m_prev};
    n_status = exp_status(m_status, v && w && a == 8'h00, d, rise);
    n_mask   = (v && w && a == 8'h04) ? (d & LOW_MASK) : m_mask;
    n_req    = |(m_status & m_mask);
    is_rd    = v && !w;
    if (is_rd) m_rdata = exp_read(a, m_status, m_mask);
    @(posedge clk);
    #1;
    m_status = n_status; m_mask = n_mask; m_prev = l; m_req = n_req;
    check("R7 request", {31'd0, req}, {31'd0, m_req});
    if (is_rd) check(rtag, rdata, m_rdata);
    valid = 1'b0; write = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] cur;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R8 rdata at reset", rdata, '0);
    check("R8 request at reset", {31'd0, req}, 32'd0);
    rst_n = 1'b1;
    cyc('0, 1, 0, 8'h00, '0, "R8 status after reset");
    cyc('0, 1, 0, 8'h04, '0, "R8 mask after reset");

    // R1: walk every line, read the status, then acknowledge.
    for (int i = 0; i < NL; i++) begin
      cyc(NL'(1) << i, 0, 0, '0, '0, "");
      cyc('0, 1, 0, 8'h00, '0, "R1 single line sets its bit");
      cyc('0, 1, 1, 8'h00, '0, "");
    end

    // R4: mask keeps only the low bits.
    cyc('0, 1, 1, 8'h04, 32'hFFFF_FFFF, "");
    cyc('0, 1, 0, 8'h04, '0, "R4 mask upper bits zero");

    // R2: held high then cleared stays clear; falling edge keeps it.
    cyc(NL'(1), 0, 0, '0, '0, "");
    cyc(NL'(1), 1, 1, 8'h00, 32'hFFFF_FFFE, "");
    cyc(NL'(1), 0, 0, '0, '0, "");
    cyc(NL'(1), 1, 0, 8'h00, '0, "R2 held line does not re-set");
    cyc(NL'(2), 0, 0, '0, '0, "");
    cyc('0, 1, 0, 8'h00, '0, "R2 falling edge keeps status");

    // R3: writing ones keeps bits, upper bits stay zero.
    cyc('0, 1, 1, 8'h00, 32'hFFFF_FFFF, "");
    cyc('0, 1, 0, 8'h00, '0, "R3 ones keep status, upper zero");

    // R9: edge on bit 3 in the same cycle as a clear of all bits.
    cyc(NL'(8), 1, 1, 8'h00, '0, "");
    cyc(NL'(8), 1, 0, 8'h00, '0, "R9 edge beats clear");

    // R6: unmapped accesses.
    cyc('0, 1, 1, 8'h08, '0, "");
    cyc('0, 1, 1, 8'hFC, '0, "");
    cyc('0, 1, 0, 8'h04, '0, "R6 unmapped write leaves mask");
    cyc('0, 1, 0, 8'h00, '0, "R6 unmapped write leaves status");
    cyc('0, 1, 0, 8'h01, '0, "R6 unmapped read all ones");

    // Random traffic, R5/R6 reads and R7 request.
    cur = '0;
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      bit v, w;
      int pick;
      for (int b = 0; b < NL; b++)
        if ($urandom_range(0, 7) == 0) cur[b] = ~cur[b];
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? 8'h00 : (pick < 8) ? 8'h04 : 8'($urandom_range(1, 255));
      v = ($urandom_range(0, 2) != 0);
      w = ($urandom_range(0, 1) != 0);
      d = $urandom;
      if (w && a == 8'h00 && $urandom_range(0, 1) == 1) d = ~(32'd1 << $urandom_range(0, NL-1));
      cyc(cur, v, w, a, d, (a == 8'h00 || a == 8'h04) ? "R5 register read" : "R6 unmapped read");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule